// File: doc/BRIEF.md
# Stop-Mode Wake and Clock Controller

This block sits beside a small microcontroller core and does two jobs. It turns the free-running oscillator into clock enables for the system domain and the timer domain. The enables are one oscillator cycle wide, and a downstream gating cell uses them. The base rate is half the oscillator rate. A control bit bypasses that halving, and a second bit adds a divide-by-16 prescaler. A new division setting is adopted only when the current divided period ends, so no enabled period is ever cut short. Both enables are held low while the core is in stop.

The block's second job is to decide which port pins may wake the core from stop. A three-bit source code in the control register picks one of the following: no pin at all, a single port-3 pin, port-2 bit 7 alone, the lower half of port 2, or all of port 2. A two-bit group field in a second register gives a fallback group choice, and it is used only when the source code is zero. Port-3 pins 1 to 3 are masked while the port is set for analog input. A port-2 pin that is driven as an output is judged by its driven level. A polarity bit sets the active level for every source. The selected signal is synchronised to the oscillator, and its rising edge during stop raises a wake request. The request is held until stop is released.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset both register fields are zero. The clock enables then pulse once every 2 oscillator cycles, and the wake request is low.
- R2: When control bit 1 (halving bypass) is 1 and bit 0 is 0, the enables pulse on every oscillator cycle.
- R3: Control bit 0 multiplies the enable period by 16. The period is 32 cycles with bit 1 at 0, and 16 cycles with bit 1 at 1.
- R4: A new division setting takes effect only when the enable period in progress ends. The period in progress completes at its old length.
- R5: While stop_i is 1, sys_ce_o and tmr_ce_o are both 0. Outside stop the two enables are equal.
- R6: Source code = control bits 4:2. Codes 1, 2, 3 and 4 select port-3 pin 0, 1, 2 and 3 respectively. Code 0 selects no pin from the control register.
- R7: Code 5 selects port-2 pin 7. Code 6 selects the OR of port-2 pins 3:0. Code 7 selects the OR of port-2 pins 7:0.
- R8: Group field = register 1 bits 1:0. It is used only when the source code is 0. Value 1 selects the OR of port-2 pins 3:0, value 2 selects the OR of pins 7:0, and values 0 and 3 select nothing. A non-zero source code overrides the group field.
- R9: While p3_analog_i is 1, port-3 pins 1 to 3 can never cause a wake. Pin 0 is not affected.
- R10: A port-2 pin whose direction bit is 1 is judged by its p2_out_i level. Otherwise it is judged by p2_in_i.
- R11: Control bit 5 sets the polarity: 1 means a high pin is active, and 0 means a low pin is active. A group is active when any member pin is active.
- R12: A change of the selected source from inactive to active during stop raises wake_o after 3 clock edges, through a two-flop synchroniser. wake_o then stays high until stop_i falls. wake_o is never high while stop_i is 0, and a source that was already active on entry into stop does not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the control register, 1 selects the group register |
| wr_data_i | input | 8 | Write data |
| stop_i | input | 1 | Core is in the stop state |
| p2_in_i | input | 8 | Port-2 pad input levels |
| p2_out_i | input | 8 | Port-2 driven output levels |
| p2_dir_i | input | 8 | Port-2 direction, 1 means output |
| p3_in_i | input | 4 | Port-3 pad input levels, pins 0 to 3 |
| p3_analog_i | input | 1 | Port 3 is configured for analog input |
| sys_ce_o | output | 1 | System clock enable |
| tmr_ce_o | output | 1 | Timer clock enable |
| wake_o | output | 1 | Wake/reset request |

## Verification
The assertions assume that stop_i and the register port are synchronous to clk_i. They also assume that a pin change lasts long enough to pass the synchroniser before anything else is judged. The stimulus drives every input at the falling edge. It puts each source into a known inactive state before stop is entered, then holds the tested pin pattern for four clock edges before wake_o is sampled. The group-field code 3 is treated as "no source". The random loop reaches it together with codes that the source field overrides, so the priority is exercised without relying on a forbidden setting.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef struct packed {
    logic       pol;
    logic [2:0] src;
    logic       bypass;
    logic       pre;
  } ctrl_t;

  typedef enum logic [1:0] {
    GRP_NONE = 2'b00,
    GRP_LOW  = 2'b01,
    GRP_ALL  = 2'b10,
    GRP_RSVD = 2'b11
  } grp_e;

  localparam logic [2:0] SRC_NONE   = 3'd0;
  localparam logic [2:0] SRC_P2_TOP = 3'd5;
  localparam logic [2:0] SRC_P2_LOW = 3'd6;
  localparam logic [2:0] SRC_P2_ALL = 3'd7;
endpackage

// File: rtl/swc_clk_div.sv
module swc_clk_div #(
  parameter int PRESCALE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic pre_i,
  input  logic stop_i,
  output logic tick_o
);
  localparam int MAX_N = 2 * PRESCALE;
  localparam int CW    = $clog2(MAX_N) + 1;

  logic [CW-1:0] cnt_q, cur_n_q, new_n;
  logic          tick;

  always_comb begin
    new_n = bypass_i ? CW'(1) : CW'(2);
    if (pre_i) new_n = new_n * CW'(PRESCALE);
  end

  assign tick = (cnt_q == cur_n_q - CW'(1));

  // period length is latched only on a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cur_n_q <= CW'(2);
    end else if (tick) begin
      cnt_q   <= '0;
      cur_n_q <= new_n;
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign tick_o = tick & ~stop_i;

  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < cur_n_q);

  a_r4_mode_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_n_q != $past(cur_n_q)) |-> $past(tick));
endmodule

// File: rtl/swc_src_sel.sv
module swc_src_sel
  import swc_pkg::*;
#(
  parameter int P2_W = 8,
  parameter int P3_W = 4
) (
  input  logic [2:0]      src_i,
  input  logic [1:0]      grp_i,
  input  logic            pol_i,
  input  logic            analog_i,
  input  logic [P2_W-1:0] p2_lvl_i,
  input  logic [P3_W-1:0] p3_lvl_i,
  output logic            active_o
);
  localparam int LOW_W = P2_W / 2;
  localparam int IDX_W = $clog2(P3_W);

  logic [P2_W-1:0] a2;
  logic [P3_W-1:0] a3;
  logic            act;

  assign a2 = pol_i ? p2_lvl_i : ~p2_lvl_i;

  for (genvar i = 0; i < P3_W; i++) begin : g_p3
    if (i == 0) begin : g_dig
      assign a3[i] = pol_i ? p3_lvl_i[i] : ~p3_lvl_i[i];
    end else begin : g_ana
      assign a3[i] = ~analog_i & (pol_i ? p3_lvl_i[i] : ~p3_lvl_i[i]);
    end
  end

  always_comb begin
    act = 1'b0;
    case (src_i)
      SRC_NONE: begin
        case (grp_e'(grp_i))
          GRP_LOW: act = |a2[LOW_W-1:0];
          GRP_ALL: act = |a2;
          default: act = 1'b0;
        endcase
      end
      SRC_P2_TOP: act = a2[P2_W-1];
      SRC_P2_LOW: act = |a2[LOW_W-1:0];
      SRC_P2_ALL: act = |a2;
      default:    act = a3[IDX_W'(src_i - 3'd1)];
    endcase
  end

  assign active_o = act;

  always_comb begin
    a_r9_analog_mask: assert (!(analog_i && (src_i inside {3'd2, 3'd3, 3'd4})) || !active_o);
    a_r8_no_source:   assert (!((src_i == SRC_NONE) && (grp_i inside {GRP_NONE, GRP_RSVD})) || !active_o);
  end
endmodule

// File: rtl/swc_wake_sync.sv
module swc_wake_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic stop_i,
  output logic wake_o
);
  logic s1_q, s2_q, prev_q, wake_q;
  logic rise;

  assign rise = s2_q & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      s1_q   <= active_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      wake_q <= stop_i ? (wake_q | rise) : 1'b0;
    end
  end

  assign wake_o = wake_q & stop_i;

  a_r12_clear_outside_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> !wake_q);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int P2_W     = 8,
  parameter int P3_W     = 4,
  parameter int DATA_W   = 8,
  parameter int PRESCALE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stop_i,
  input  logic [P2_W-1:0]   p2_in_i,
  input  logic [P2_W-1:0]   p2_out_i,
  input  logic [P2_W-1:0]   p2_dir_i,
  input  logic [P3_W-1:0]   p3_in_i,
  input  logic              p3_analog_i,
  output logic              sys_ce_o,
  output logic              tmr_ce_o,
  output logic              wake_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t           ctrl_q;
  logic [1:0]      grp_q;
  logic [P2_W-1:0] p2_lvl;
  logic            active, tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      grp_q  <= '0;
    end else if (wr_en_i) begin
      if (!wr_addr_i) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      else            grp_q  <= wr_data_i[1:0];
    end
  end

  // output-mode pins are judged by their driven level
  assign p2_lvl = (p2_dir_i & p2_out_i) | (~p2_dir_i & p2_in_i);

  swc_clk_div #(.PRESCALE(PRESCALE)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (ctrl_q.bypass),
    .pre_i    (ctrl_q.pre),
    .stop_i   (stop_i),
    .tick_o   (tick)
  );

  swc_src_sel #(.P2_W(P2_W), .P3_W(P3_W)) u_sel (
    .src_i    (ctrl_q.src),
    .grp_i    (grp_q),
    .pol_i    (ctrl_q.pol),
    .analog_i (p3_analog_i),
    .p2_lvl_i (p2_lvl),
    .p3_lvl_i (p3_in_i),
    .active_o (active)
  );

  swc_wake_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .stop_i   (stop_i),
    .wake_o   (wake_o)
  );

  assign sys_ce_o = tick;
  assign tmr_ce_o = tick;

  a_r5_no_ce_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !sys_ce_o && !tmr_ce_o);
endmodule

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       stop = 1'b0;
  logic [7:0] p2_in = '0, p2_out = '0, p2_dir = '0;
  logic [3:0] p3_in = '0;
  logic       p3_an = 1'b0;
  logic       sys_ce, tmr_ce, wake;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  stop_wake_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .stop_i(stop), .p2_in_i(p2_in), .p2_out_i(p2_out),
    .p2_dir_i(p2_dir), .p3_in_i(p3_in), .p3_analog_i(p3_an),
    .sys_ce_o(sys_ce), .tmr_ce_o(tmr_ce), .wake_o(wake)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_act(input logic [7:0] ctrl, input logic [1:0] sec, input bit an,
                                 input logic [7:0] dir, input logic [7:0] out,
                                 input logic [7:0] inp, input logic [3:0] p3);
    logic [7:0] lvl, a2;
    logic [3:0] a3;
    lvl = (dir & out) | (~dir & inp);
    a2  = ctrl[5] ? lvl : ~lvl;
    a3  = ctrl[5] ? p3 : ~p3;
    if (an) a3[3:1] = 3'b000;
    case (ctrl[4:2])
      3'd0: return (sec == 2'd1) ? |a2[3:0] : (sec == 2'd2) ? |a2 : 1'b0;
      3'd1: return a3[0];
      3'd2: return a3[1];
      3'd3: return a3[2];
      3'd4: return a3[3];
      3'd5: return a2[7];
      3'd6: return |a2[3:0];
      default: return |a2;
    endcase
  endfunction

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      check(sys_ce == tmr_ce, "R5 enables equal", int'(tmr_ce), int'(sys_ce));
    end while (!sys_ce);
  endtask

  task automatic run_wake(input logic [7:0] ctrl, input logic [1:0] sec, input bit an,
                          input logic [7:0] dir, input logic [7:0] out, input logic [7:0] inp,
                          input logic [3:0] p3, input string req);
    bit e;
    stop = 1'b0; p2_dir = '0; p2_out = '0;
    p2_in = ctrl[5] ? 8'h00 : 8'hFF;
    p3_in = ctrl[5] ? 4'h0 : 4'hF;
    p3_an = an;
    wr(1'b0, ctrl);
    wr(1'b1, {6'b0, sec});
    repeat (4) @(negedge clk);
    stop = 1'b1;
    repeat (4) @(negedge clk);
    check(wake == 1'b0, {req, " idle"}, int'(wake), 0);
    p2_dir = dir; p2_out = out; p2_in = inp; p3_in = p3;
    e = exp_act(ctrl, sec, an, dir, out, inp, p3);
    repeat (4) @(negedge clk);
    check(wake == e, req, int'(wake), int'(e));
    stop = 1'b0;
    #1;
    check(wake == 1'b0, "R12 low outside stop", int'(wake), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g;
    int cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(sys_ce == 1'b0 && wake == 1'b0, "R1 reset outputs", int'(sys_ce), 0);
    rst_n = 1'b1;

    // R1: default halving
    measure(g);
    measure(g);
    check(g == 2, "R1 default period", g, 2);

    // R4: prescaler written right after an enable; the old period finishes first
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    check(sys_ce == 1'b0, "R4 no early pulse", int'(sys_ce), 0);
    measure(g);
    check(g == 1, "R4 old period kept", g, 1);
    measure(g);
    check(g == 32, "R3 prescale with halving", g, 32);

    // R3: prescale with bypass
    wr(1'b0, 8'h03);
    measure(g); measure(g);
    check(g == 16, "R3 prescale bypass", g, 16);

    // R2: bypass only
    wr(1'b0, 8'h02);
    measure(g); measure(g);
    check(g == 1, "R2 bypass period", g, 1);
    measure(g);
    check(g == 1, "R2 bypass steady", g, 1);

    // R5: stop gates enables
    stop = 1'b1;
    cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (sys_ce || tmr_ce) cnt++;
    end
    check(cnt == 0, "R5 enables gated in stop", cnt, 0);
    stop = 1'b0;

    // R6: each port-3 pin
    run_wake(8'h24, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0001, "R6 code1 pin0");
    run_wake(8'h28, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0010, "R6 code2 pin1");
    run_wake(8'h2C, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0100, "R6 code3 pin2");
    run_wake(8'h30, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b1000, "R6 code4 pin3");
    run_wake(8'h24, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b1110, "R6 other pins ignored");
    run_wake(8'h20, 2'd0, 1'b0, 8'h00, 8'h00, 8'hFF, 4'hF, "R6 code0 no source");
    // R7
    run_wake(8'h34, 2'd0, 1'b0, 8'h00, 8'h00, 8'h80, 4'h0, "R7 code5 p2 pin7");
    run_wake(8'h34, 2'd0, 1'b0, 8'h00, 8'h00, 8'h7F, 4'h0, "R7 code5 ignores low pins");
    run_wake(8'h38, 2'd0, 1'b0, 8'h00, 8'h00, 8'h04, 4'h0, "R7 code6 low group");
    run_wake(8'h38, 2'd0, 1'b0, 8'h00, 8'h00, 8'hF0, 4'h0, "R7 code6 ignores upper");
    run_wake(8'h3C, 2'd0, 1'b0, 8'h00, 8'h00, 8'h20, 4'h0, "R7 code7 all group");
    // R8
    run_wake(8'h20, 2'd1, 1'b0, 8'h00, 8'h00, 8'h04, 4'h0, "R8 group low hit");
    run_wake(8'h20, 2'd1, 1'b0, 8'h00, 8'h00, 8'h20, 4'h0, "R8 group low miss");
    run_wake(8'h20, 2'd2, 1'b0, 8'h00, 8'h00, 8'h20, 4'h0, "R8 group all hit");
    run_wake(8'h20, 2'd3, 1'b0, 8'h00, 8'h00, 8'hFF, 4'h0, "R8 group code3 none");
    run_wake(8'h24, 2'd2, 1'b0, 8'h00, 8'h00, 8'h20, 4'h0, "R8 source overrides group");
    // R9
    run_wake(8'h28, 2'd0, 1'b1, 8'h00, 8'h00, 8'h00, 4'b0010, "R9 analog masks pin1");
    run_wake(8'h30, 2'd0, 1'b1, 8'h00, 8'h00, 8'h00, 4'b1000, "R9 analog masks pin3");
    run_wake(8'h24, 2'd0, 1'b1, 8'h00, 8'h00, 8'h00, 4'b0001, "R9 pin0 unmasked");
    // R10
    run_wake(8'h34, 2'd0, 1'b0, 8'h80, 8'h80, 8'h00, 4'h0, "R10 output level wakes");
    run_wake(8'h34, 2'd0, 1'b0, 8'h80, 8'h00, 8'h80, 4'h0, "R10 pad ignored for output");
    run_wake(8'h34, 2'd0, 1'b0, 8'h00, 8'h80, 8'h00, 4'h0, "R10 out ignored for input");
    // R11
    run_wake(8'h04, 2'd0, 1'b0, 8'h00, 8'h00, 8'hFF, 4'b1110, "R11 active low wakes");
    run_wake(8'h04, 2'd0, 1'b0, 8'h00, 8'h00, 8'hFF, 4'b0001, "R11 active low idle");
    run_wake(8'h1C, 2'd0, 1'b0, 8'h00, 8'h00, 8'hFE, 4'hF, "R11 low group any member");

    // R12: latency, hold, edge only
    run_wake(8'h24, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, "R12 setup");
    p3_in = 4'h0; stop = 1'b1;
    repeat (4) @(negedge clk);
    p3_in = 4'h1;
    @(negedge clk);
    check(wake == 1'b0, "R12 latency edge1", int'(wake), 0);
    @(negedge clk);
    check(wake == 1'b0, "R12 latency edge2", int'(wake), 0);
    @(negedge clk);
    check(wake == 1'b1, "R12 latency edge3", int'(wake), 1);
    p3_in = 4'h0;
    repeat (6) @(negedge clk);
    check(wake == 1'b1, "R12 held", int'(wake), 1);
    stop = 1'b0;
    #1;
    check(wake == 1'b0, "R12 drop with stop", int'(wake), 0);
    p3_in = 4'h1;
    repeat (5) @(negedge clk);
    stop = 1'b1;
    repeat (5) @(negedge clk);
    check(wake == 1'b0, "R12 level before stop ignored", int'(wake), 0);
    stop = 1'b0;

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [7:0] c, d, o, n;
      logic [3:0] p;
      logic [1:0] s;
      c = 8'($urandom) & 8'h3C;
      s = 2'($urandom);
      d = 8'($urandom); o = 8'($urandom); n = 8'($urandom);
      p = 4'($urandom);
      run_wake(c, s, 1'($urandom), d, o, n, p, "R11 random source");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule